// File: doc/BRIEF.md
# DRAM Refresh Request Timer

This block paces distributed CAS-before-RAS refresh for a DRAM controller. A free-running prescaler divides the system clock by one of seven fixed ratios. The ratio is chosen by a 3-bit select field, and the chosen ratio advances a 16-bit up-counter. Each time the counter meets a programmed limit, the counter wraps to zero. If distributed refresh is switched on, a refresh request is latched at the same time and shown on a status pin.

The latched request waits until the external bus arbiter grants the bus. While the grant is held, the first idle cycle starts a CAS-before-RAS strobe sequence, and that start is what clears the request. If another limit match arrives while a request is still waiting, a sticky overflow flag is set. Software clears it by reading the status word.

Software reaches the block through a small word-wide register port. There are four words: control, limit, counter and status.

Top module: `refresh_req_timer`

## Requirements
- R1: After reset, the control, limit and counter words read 0, the status word reads 0, `refresh_pending` and `cbr_done` are 0, and `cas_n` and `ras_n` are 1.
- R2: While the select field (control bits [2:0]) is 000, the counter does not change unless software writes it.
- R3: When the select field goes from 000 to a nonzero code, counting resumes from the value the counter already holds. The counter is not cleared.
- R4: Select codes 1 to 7 advance the counter once every 4, 16, 64, 256, 1024, 2048 and 4096 system clocks respectively.
- R5: On a count step that finds the counter equal to the limit (address 1), the counter becomes 0 instead of incrementing. With limit L and the counter starting at 0, the request appears L+1 count steps later.
- R6: A limit match latches a request only when the enable bit (control bit 3) is 1 and the mode bit (control bit 4) is 0. `refresh_pending` shows the latched request.
- R7: A latched request stays set while `bus_grant` is low. It clears on the clock edge where `bus_grant` is high and the sequencer is idle, which is the edge that starts the refresh cycle.
- R8: The strobe sequence drives `cas_n` low for one cycle with `ras_n` still high. It then holds both low for H cycles, where H is control bits [8:5]. It then raises both together while `cbr_done` pulses for one cycle, and then goes idle.
- R9: A limit match that would latch a request while one is already pending and not starting sets status bit 0. The bit stays set until a read of the status word (address 3). Status bit 1 shows the pending request.
- R10: A hold field of 0 is treated as a hold of one cycle.
- R11: A write to the counter word (address 2) loads that value into the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears overflow when reading status) |
| reg_addr | input | 2 | Word select: 0 control, 1 limit, 2 counter, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| bus_grant | input | 1 | Arbiter grants the external bus |
| refresh_pending | output | 1 | Refresh request latched and waiting |
| cas_n | output | 1 | Column strobe, active low |
| ras_n | output | 1 | Row strobe, active low |
| cbr_done | output | 1 | One-cycle pulse when the refresh cycle ends |

## Verification
Reads are combinational, so register values are sampled mid-cycle just after the address is driven. Prescaler ratios are checked by reading the counter twice, a whole number of prescale periods apart, so the phase of the prescaler does not matter. A request appears on the status pin one edge after the matching count step, and it is sampled at the next falling edge. The check allows the span of edges the unknown prescaler phase permits. The strobe pattern is due from the edge after the grant is driven onward, one entry per cycle. A scoreboard queue is filled when the grant is driven and drained 5 ns after each rising edge, so each entry is compared in the cycle it belongs to.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_CAS,
    SEQ_HOLD,
    SEQ_DONE
  } seq_state_e;

  // log2 of the divide ratio for each select code; 0 means stopped
  function automatic int unsigned sel_shift(input logic [2:0] sel);
    case (sel)
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      3'd6:    return 11;
      3'd7:    return 12;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rrt_prescaler.sv
module rrt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [7:0]       tick_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick_vec[0] = 1'b0;

  for (genvar c = 1; c < 8; c++) begin : g_ratio
    localparam int RAW = rrt_pkg::sel_shift(3'(c));
    localparam int SH  = (RAW > PRE_W) ? PRE_W : RAW;
    assign tick_vec[c] = &pre_q[SH-1:0];
  end

  assign tick = tick_vec[sel];
endmodule

// File: rtl/rrt_counter.sv
module rrt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q;

  assign match = tick && (cnt_q == limit);
  assign cnt   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_wr) cnt_q <= cnt_wdata;
    else if (match)  cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rrt_cbr_seq.sv
module rrt_cbr_seq #(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HOLD_W-1:0] hold_cfg,
  output logic              cas_n,
  output logic              ras_n,
  output logic              done,
  output logic              idle
);
  import rrt_pkg::*;

  seq_state_e        state_q;
  logic [HOLD_W-1:0] hcnt_q;
  logic [HOLD_W-1:0] hold_eff;

  assign hold_eff = (hold_cfg == '0) ? HOLD_W'(1) : hold_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      hcnt_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start) state_q <= SEQ_CAS;
        SEQ_CAS: begin
          state_q <= SEQ_HOLD;
          hcnt_q  <= hold_eff - 1'b1;
        end
        SEQ_HOLD: begin
          if (hcnt_q == '0) state_q <= SEQ_DONE;
          else              hcnt_q  <= hcnt_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign idle  = (state_q == SEQ_IDLE);
  assign cas_n = !((state_q == SEQ_CAS) || (state_q == SEQ_HOLD));
  assign ras_n = (state_q != SEQ_HOLD);
  assign done  = (state_q == SEQ_DONE);
endmodule

// File: rtl/refresh_req_timer.sv
module refresh_req_timer #(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 12,
  parameter int HOLD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             bus_grant,
  output logic             refresh_pending,
  output logic             cas_n,
  output logic             ras_n,
  output logic             cbr_done
);
  localparam int CTRL_W = 5 + HOLD_W;

  logic [2:0]        sel_q;
  logic              en_q, mode_q;
  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  limit_q;
  logic              req_q, ovf_q;

  // named internal events
  logic             tick, match_evt, active, set_req, seq_start, seq_idle;
  logic             cnt_wr, ctrl_wr, limit_wr, stat_rd;
  logic [CNT_W-1:0] cnt_val;

  assign ctrl_wr   = reg_wr && (reg_addr == 2'd0);
  assign limit_wr  = reg_wr && (reg_addr == 2'd1);
  assign cnt_wr    = reg_wr && (reg_addr == 2'd2);
  assign stat_rd   = reg_rd && (reg_addr == 2'd3);
  assign active    = en_q && !mode_q;
  assign set_req   = match_evt && active;
  assign seq_start = req_q && bus_grant && seq_idle;

  rrt_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .tick(tick)
  );

  rrt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr),
    .cnt_wdata(reg_wdata), .limit(limit_q), .cnt(cnt_val), .match(match_evt)
  );

  rrt_cbr_seq #(.HOLD_W(HOLD_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .hold_cfg(hold_q),
    .cas_n(cas_n), .ras_n(ras_n), .done(cbr_done), .idle(seq_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      hold_q  <= '0;
      limit_q <= '0;
    end else begin
      if (ctrl_wr) begin
        sel_q  <= reg_wdata[2:0];
        en_q   <= reg_wdata[3];
        mode_q <= reg_wdata[4];
        hold_q <= reg_wdata[CTRL_W-1:5];
      end
      if (limit_wr) limit_q <= reg_wdata;
    end
  end

  // a new request wins over the clear by the refresh start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (set_req)        req_q <= 1'b1;
      else if (seq_start) req_q <= 1'b0;
      if (set_req && req_q && !seq_start) ovf_q <= 1'b1;
      else if (stat_rd)                   ovf_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = CNT_W'({hold_q, mode_q, en_q, sel_q});
      2'd1:    reg_rdata = limit_q;
      2'd2:    reg_rdata = cnt_val;
      default: reg_rdata = CNT_W'({req_q, ovf_q});
    endcase
  end

  assign refresh_pending = req_q;
endmodule

// File: rtl/rrt_checker.sv
module rrt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       sel,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_wr,
  input logic             match_evt,
  input logic             active,
  input logic             seq_start,
  input logic             pending,
  input logic             ovf,
  input logic             cas_n,
  input logic             ras_n,
  input logic             done
);
  // R2
  counter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 && !cnt_wr) |=> $stable(cnt));

  // R5
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !cnt_wr) |=> (cnt == '0));

  // R6
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(match_evt && active));

  // R7
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(seq_start));

  // R8
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

  // R8
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $rose(cas_n));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ras_n && cas_n && !$past(ras_n)));

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(pending && match_evt && active));
endmodule

bind refresh_req_timer rrt_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel_q), .cnt(cnt_val), .cnt_wr(cnt_wr),
  .match_evt(match_evt), .active(active), .seq_start(seq_start),
  .pending(req_q), .ovf(ovf_q), .cas_n(cas_n), .ras_n(ras_n), .done(cbr_done)
);

// File: tb/test_refresh_req_timer.sv
`timescale 1ns/1ps
module test_refresh_req_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, bus_grant = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        refresh_pending, cas_n, ras_n, cbr_done;

  int checks = 0, fails = 0;
  logic [2:0] sb_q[$];   // {cas_n, ras_n, done} per cycle

  always #10 clk = ~clk;

  refresh_req_timer i_refresh_req_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_grant(bus_grant), .refresh_pending(refresh_pending),
    .cas_n(cas_n), .ras_n(ras_n), .cbr_done(cbr_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  function automatic logic [15:0] ctrl(input int sel, input int en, input int mode, input int hold);
    return 16'((hold << 5) | (mode << 4) | (en << 3) | sel);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd_clear();
    @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd3;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_pending(output int n);
    n = 0;
    while (!refresh_pending && n < 100) begin @(negedge clk); n++; end
  endtask

  // driver: grant the bus and queue the expected strobe pattern
  task automatic grant_and_expect(input int hold);
    @(negedge clk); bus_grant = 1'b1;
    sb_q.push_back(3'b010);                          // CAS only
    for (int i = 0; i < hold; i++) sb_q.push_back(3'b000);
    sb_q.push_back(3'b111);                          // release + done
    sb_q.push_back(3'b110);                          // idle
    @(negedge clk); bus_grant = 1'b0;
    // R7: cleared by the start edge
    check(refresh_pending == 1'b0, "R7 clear on start", int'(refresh_pending), 0);
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  // monitor: compare strobes 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (sb_q.size() > 0) begin
      logic [2:0] e, a;
      e = sb_q.pop_front();
      a = {cas_n, ras_n, cbr_done};
      check(a == e, "R8 strobe sequence", int'(a), int'(e));
    end
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    logic [15:0] a, b, v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(2'd0, a); check(a == 0, "R1 ctrl reset", a, 0);
    rd(2'd1, a); check(a == 0, "R1 limit reset", a, 0);
    rd(2'd2, a); check(a == 0, "R1 counter reset", a, 0);
    rd(2'd3, a); check(a == 0, "R1 status reset", a, 0);
    check({refresh_pending, cas_n, ras_n, cbr_done} == 4'b0110, "R1 pins reset",
          int'({refresh_pending, cas_n, ras_n, cbr_done}), 6);

    // R11 and R4 with /4
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'd100);
    rd(2'd2, a); check(a == 100, "R11 counter load", a, 100);
    wr(2'd0, ctrl(1, 0, 0, 0));
    rd(2'd2, a);
    repeat (64) @(negedge clk);
    rd(2'd2, b); check(16'(b - a) == 16, "R4 ratio /4", int'(16'(b - a)), 16);

    // R2 stopped
    wr(2'd0, ctrl(0, 0, 0, 0));
    rd(2'd2, v);
    repeat (50) @(negedge clk);
    rd(2'd2, a); check(a == v, "R2 stopped", a, v);

    // R3 resume without clearing, R4 /16
    wr(2'd0, ctrl(2, 0, 0, 0));
    rd(2'd2, a); check(a == v, "R3 no clear on restart", a, v);
    repeat (256) @(negedge clk);
    rd(2'd2, b); check(16'(b - v) == 16, "R3 R4 resume /16", int'(16'(b - v)), 16);

    // R4 /4096
    wr(2'd0, ctrl(7, 0, 0, 0));
    rd(2'd2, a);
    repeat (4096) @(negedge clk);
    rd(2'd2, b); check(16'(b - a) == 1, "R4 ratio /4096", int'(16'(b - a)), 1);

    // R6: no request with mode=1 or enable=0
    wr(2'd0, 16'd0); wr(2'd1, 16'd3); wr(2'd2, 16'd0);
    wr(2'd0, ctrl(1, 1, 1, 0));
    n = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (refresh_pending) n++; end
    check(n == 0, "R6 mode bit blocks request", n, 0);
    wr(2'd0, ctrl(1, 0, 0, 0));
    n = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (refresh_pending) n++; end
    check(n == 0, "R6 enable bit blocks request", n, 0);

    // R5, R6: request timing and counter clear
    wr(2'd0, 16'd0); wr(2'd2, 16'd0);
    wr(2'd0, ctrl(1, 1, 0, 2));
    wait_pending(n);
    check(n >= 13 && n <= 16, "R5 R6 request after limit+1 steps", n, 16);
    rd(2'd2, a); check(a == 0, "R5 counter cleared on match", a, 0);

    // R7 held without grant
    repeat (8) @(negedge clk);
    check(refresh_pending && cas_n, "R7 held without grant",
          int'({refresh_pending, cas_n}), 3);

    // R9 overflow on second match
    repeat (20) @(negedge clk);
    wr(2'd0, ctrl(0, 1, 0, 2));
    rd(2'd3, a); check(a == 3, "R9 overflow and pending", a, 3);
    rd_clear();
    rd(2'd3, a); check(a == 2, "R9 overflow cleared by read", a, 2);

    // R8 sequence with hold 2
    grant_and_expect(2);

    // R10 hold field zero acts as one
    wr(2'd2, 16'd0);
    wr(2'd0, ctrl(1, 1, 0, 0));
    wait_pending(n);
    check(refresh_pending == 1'b1, "R10 request present", int'(refresh_pending), 1);
    wr(2'd0, ctrl(0, 1, 0, 0));
    grant_and_expect(1);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule